// File: doc/BRIEF.md
# Escaped Packet Framing Encoder

This block turns one transaction's worth of payload bytes into a framed byte stream that is ready for a serial link. Each frame opens with a start code, a channel code and a channel number of zero. Payload values that would be mistaken for control codes are replaced by a two-byte escape sequence, and an end code marks the final payload byte.

Payload arrives on a valid/ready byte port, and a last flag tags the closing byte of a transaction. The block collects the whole payload of a frame in a small buffer and then plays the encoded frame out on a valid/ready output port. With `ALIGN_EN` set, the frame is padded with idle codes to a whole number of 4-byte words. The idle codes go just ahead of the end code, so the end code and the byte after it always finish the last word. With `ALIGN_EN` clear, the stream is byte-wide and unpadded.

Top module: `esc_frame_enc`

## Requirements
- R1: Every frame begins with the three bytes 0x7A (start code), 0x7C (channel code), 0x00 (channel number).
- R2: A payload byte of value 0x7A, 0x7B, 0x7C or 0x7D goes out as 0x7D followed by the byte XOR 0x20.
- R3: A payload byte of value 0x4A or 0x4D goes out as 0x4D followed by the byte XOR 0x20. All other payload values go out unchanged.
- R4: The end code 0x7B comes immediately before the final payload byte. That byte is escaped by R2/R3 like any other, and it closes the frame.
- R5: With `ALIGN_EN`=1, idle bytes 0x4A are inserted directly before the end code, as many as bring the frame length to a multiple of 4 (0 to 3).
- R6: With `ALIGN_EN`=0, no idle bytes are inserted, so the frame is 4 + the encoded payload length.
- R7: `s_ready` is high only while a frame is being collected. It is low from the byte that closes the frame until the last encoded byte is accepted. Under any `m_ready` pattern, no byte is lost or repeated, and `m_valid`/`m_data` hold while stalled.
- R8: A frame closes after `MAX_PAYLOAD` bytes even without a last flag. The worst case (all bytes escaped) emits 2*`MAX_PAYLOAD`+4 bytes correctly.
- R9: After reset, `s_ready` is 1 and `m_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Payload byte valid |
| s_ready | output | 1 | Block accepts payload byte |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Byte is the last of the transaction |
| m_valid | output | 1 | Encoded byte valid |
| m_ready | input | 1 | Downstream accepts encoded byte |
| m_data | output | 8 | Encoded byte |

## Verification
The assertions assume that the upstream side holds `s_data` and `s_last` while it waits. They also assume that frames stay within `MAX_PAYLOAD` bytes, or rely on the forced close. The escape-follow checks depend on the fact that raw 0x7D and 0x4D never appear in the output except as prefixes. The stimulus keeps to this: every frame is fully drained before the next one starts, and `s_valid` is driven only between frames. Output backpressure follows a periodic stall pattern, which gives the hold-while-stalled property both stalled and moving cycles to check.

// File: rtl/esc_frame_enc.sv
module esc_frame_enc #(
  parameter int MAX_PAYLOAD = 32,
  parameter bit ALIGN_EN    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data
);
  localparam int CW = $clog2(MAX_PAYLOAD + 1);
  localparam int AW = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1;

  typedef enum logic [2:0] {S_FILL, S_SOP, S_CHM, S_CHN, S_DATA, S_PAD, S_EOP, S_TAIL} st_t;

  st_t           st;
  logic [7:0]    mem [MAX_PAYLOAD];
  logic [CW-1:0] cnt, rd;
  logic [1:0]    sum, pad;
  logic          esc_ph;

  function automatic logic is_pkt(input logic [7:0] b);
    return (b == 8'h7A) || (b == 8'h7B) || (b == 8'h7C) || (b == 8'h7D);
  endfunction
  function automatic logic is_phy(input logic [7:0] b);
    return (b == 8'h4A) || (b == 8'h4D);
  endfunction

  wire acc  = s_valid && s_ready;
  wire fire = m_valid && m_ready;

  assign s_ready = (st == S_FILL);
  assign m_valid = (st != S_FILL);

  wire [AW-1:0] tail_idx = AW'(cnt - CW'(1));
  wire [7:0]    cur      = (st == S_TAIL) ? mem[tail_idx] : mem[AW'(rd)];
  wire          cur_pkt  = is_pkt(cur);
  wire          cur_phy  = is_phy(cur);
  wire          done_b   = esc_ph || !(cur_pkt || cur_phy);
  wire [7:0]    byte_out = esc_ph  ? (cur ^ 8'h20) :
                           cur_pkt ? 8'h7D :
                           cur_phy ? 8'h4D : cur;

  wire [1:0] sum_n    = sum + ((is_pkt(s_data) || is_phy(s_data)) ? 2'd2 : 2'd1);
  wire       pad_any  = ALIGN_EN && (pad != 2'd0);
  st_t       after_dt;
  assign after_dt = pad_any ? S_PAD : S_EOP;
  wire       frame_end = fire && (st == S_TAIL) && done_b;

  always_comb begin
    case (st)
      S_SOP:          m_data = 8'h7A;
      S_CHM:          m_data = 8'h7C;
      S_CHN:          m_data = 8'h00;
      S_PAD:          m_data = 8'h4A;
      S_EOP:          m_data = 8'h7B;
      S_DATA, S_TAIL: m_data = byte_out;
      default:        m_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (acc) mem[AW'(cnt)] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_FILL;
      cnt    <= '0;
      rd     <= '0;
      sum    <= '0;
      pad    <= '0;
      esc_ph <= 1'b0;
    end else if (acc) begin
      cnt <= cnt + CW'(1);
      sum <= sum_n;
      if (s_last || cnt == CW'(MAX_PAYLOAD - 1)) begin
        st  <= S_SOP;
        pad <= 2'd0 - sum_n;
      end
    end else if (fire) begin
      case (st)
        S_SOP: st <= S_CHM;
        S_CHM: st <= S_CHN;
        S_CHN: begin
          rd <= '0;
          st <= (cnt > CW'(1)) ? S_DATA : after_dt;
        end
        S_DATA: begin
          if (done_b) begin
            esc_ph <= 1'b0;
            rd     <= rd + CW'(1);
            if (rd == cnt - CW'(2)) st <= after_dt;
          end else begin
            esc_ph <= 1'b1;
          end
        end
        S_PAD: begin
          pad <= pad - 2'd1;
          if (pad == 2'd1) st <= S_EOP;
        end
        S_EOP: st <= S_TAIL;
        S_TAIL: begin
          if (done_b) begin
            esc_ph <= 1'b0;
            st     <= S_FILL;
            cnt    <= '0;
            sum    <= '0;
          end else begin
            esc_ph <= 1'b1;
          end
        end
        default: st <= S_FILL;
      endcase
    end
  end

  logic [1:0] ocnt;
  always_ff @(posedge clk) begin
    if (!rst_n)         ocnt <= '0;
    else if (frame_end) ocnt <= '0;
    else if (fire)      ocnt <= ocnt + 2'd1;
  end

  // R1
  hdr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && st == S_SOP) |=> (m_valid && m_data == 8'h7C));

  // R2
  pkt_esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && m_data == 8'h7D) |=> (m_valid && (m_data == 8'h5A || m_data == 8'h5B ||
                                               m_data == 8'h5C || m_data == 8'h5D)));

  // R3
  phy_esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && m_data == 8'h4D) |=> (m_valid && (m_data == 8'h6A || m_data == 8'h6D)));

  // R4
  eop_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && m_data == 8'h7B) |=> (m_valid && m_data != 8'h4A && m_data != 8'h7B));

  // R5
  align_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ALIGN_EN && frame_end) |-> (ocnt == 2'd3));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_PAYLOAD));
endmodule

// File: tb/esc_frame_enc_tb.sv
`timescale 1ns/1ps
module esc_frame_enc_tb_top;
  localparam int MAXP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b1;
  logic [7:0] s_data = 8'h00;
  logic a_sr, a_mv, b_sr, b_mv;
  logic [7:0] a_md, b_md;

  always #4 clk = ~clk;

  esc_frame_enc #(.MAX_PAYLOAD(MAXP), .ALIGN_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(a_sr), .s_data(s_data),
    .s_last(s_last), .m_valid(a_mv), .m_ready(m_ready), .m_data(a_md));

  esc_frame_enc #(.MAX_PAYLOAD(MAXP), .ALIGN_EN(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(b_sr), .s_data(s_data),
    .s_last(s_last), .m_valid(b_mv), .m_ready(m_ready), .m_data(b_md));

  localparam int NV = 6;
  localparam logic [63:0] TV_PAY [NV] = '{
    64'h0000_0000_0000_0011,
    64'h0000_0000_0403_0201,
    64'h0000_0000_0010_4A7A,
    64'h0000_0000_0000_7D20,
    64'h0000_4D4A_7D7C_7B7A,
    64'h007E_794E_4C5A_FF00};
  localparam int TV_LEN  [NV] = '{1, 4, 3, 2, 6, 7};
  localparam int TV_ALEN [NV] = '{8, 8, 12, 8, 16, 12};
  localparam int TV_BLEN [NV] = '{5, 8, 9, 7, 16, 11};

  int tests = 0, fails = 0;
  logic [7:0] pay [40];
  logic [7:0] got_a [128], got_b [128], exp_a [128], exp_b [128], mdl [128];
  int na = 0, nb = 0, mdl_n = 0, viol = 0;
  int bp_cnt = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) begin
    #1;
    bp_cnt = bp_cnt + 1;
    m_ready = !bp_en || (bp_cnt % 3 != 0);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (a_mv && m_ready && na < 128) begin got_a[na] = a_md; na = na + 1; end
      if (b_mv && m_ready && nb < 128) begin got_b[nb] = b_md; nb = nb + 1; end
      if ((a_mv && a_sr) || (b_mv && b_sr)) viol = viol + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    mdl[mdl_n] = b;
    mdl_n = mdl_n + 1;
  endtask

  function automatic int esz(input logic [7:0] b);
    return (b inside {8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h4A, 8'h4D}) ? 2 : 1;
  endfunction

  task automatic put_enc(input logic [7:0] b);
    if (b inside {8'h7A, 8'h7B, 8'h7C, 8'h7D}) begin put(8'h7D); put(b ^ 8'h20); end
    else if (b == 8'h4A || b == 8'h4D) begin put(8'h4D); put(b ^ 8'h20); end
    else put(b);
  endtask

  task automatic model(input int len, input bit align);
    int total;
    mdl_n = 0;
    put(8'h7A); put(8'h7C); put(8'h00);
    for (int i = 0; i < len - 1; i++) put_enc(pay[i]);
    total = mdl_n + 1 + esz(pay[len-1]);
    if (align) while (total % 4 != 0) begin put(8'h4A); total = total + 1; end
    put(8'h7B);
    put_enc(pay[len-1]);
  endtask

  task automatic run_frame(input int len, input bit use_last, input int alen, input int blen,
                           input string req);
    int ea, eb;
    model(len, 1'b1); ea = mdl_n;
    for (int i = 0; i < mdl_n; i++) exp_a[i] = mdl[i];
    model(len, 1'b0); eb = mdl_n;
    for (int i = 0; i < mdl_n; i++) exp_b[i] = mdl[i];
    na = 0; nb = 0; viol = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      s_valid = 1'b1; s_data = pay[i]; s_last = use_last && (i == len - 1);
      do @(negedge clk); while (!(a_sr && b_sr));
    end
    @(posedge clk); #1;
    s_valid = 1'b0; s_last = 1'b0;
    while (na < ea || nb < eb) @(negedge clk);
    repeat (4) @(negedge clk);
    check(na == alen, {req, " R5 aligned length"}, na, alen);
    check(nb == blen, {req, " R6 byte-mode length"}, nb, blen);
    begin
      int bad_a = -1, bad_b = -1;
      for (int i = ea - 1; i >= 0; i--) if (got_a[i] !== exp_a[i]) bad_a = i;
      for (int i = eb - 1; i >= 0; i--) if (got_b[i] !== exp_b[i]) bad_b = i;
      check(bad_a < 0, {req, " R1 R2 R3 R4 R5 aligned bytes"},
            (bad_a < 0) ? 0 : int'(got_a[bad_a]), (bad_a < 0) ? 0 : int'(exp_a[bad_a]));
      check(bad_b < 0, {req, " R1 R2 R3 R4 R6 byte-mode bytes"},
            (bad_b < 0) ? 0 : int'(got_b[bad_b]), (bad_b < 0) ? 0 : int'(exp_b[bad_b]));
    end
    check(viol == 0, {req, " R7 s_ready low while emitting"}, viol, 0);
    check(a_sr && b_sr && !a_mv && !b_mv, {req, " R7 idle after frame"},
          {a_sr, b_sr, a_mv, b_mv}, 4'b1100);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(a_sr && b_sr, "R9 s_ready after reset", {a_sr, b_sr}, 2'b11);
    check(!a_mv && !b_mv, "R9 m_valid after reset", {a_mv, b_mv}, 2'b00);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 8; i++) pay[i] = TV_PAY[v][8*i +: 8];
      bp_en = (v % 2 == 1);
      run_frame(TV_LEN[v], 1'b1, TV_ALEN[v], TV_BLEN[v], $sformatf("vec%0d", v));
    end

    // R8: worst case, no last flag, closes at MAXP bytes
    bp_en = 1'b1;
    for (int i = 0; i < MAXP; i++) pay[i] = 8'h7D;
    run_frame(MAXP, 1'b0, 2 * MAXP + 4, 2 * MAXP + 4, "R8 worst-case forced close");

    // R7: long stall, then a plain frame
    bp_en = 1'b0;
    for (int i = 0; i < 5; i++) pay[i] = 8'(8'h30 + i);
    run_frame(5, 1'b1, 12, 9, "R7 after worst case");

    // R4: two-byte frame, last byte is the phy idle value
    pay[0] = 8'h4D; pay[1] = 8'h4A;
    run_frame(2, 1'b1, 8, 8, "R4 escaped tail");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule